// File: doc/BRIEF.md
# Translation Lookaside Buffer with Last-Translation Register

This block turns a virtual page number into a physical frame number for a memory management unit. It holds a small, fully associative set of translations. Each slot keeps its virtual page tag, its frame, and three control flags: valid, referenced and modified. In front of that set sits a single register that remembers the most recent translation. A request that matches this register is answered one cycle sooner than a request that has to search the set.

When neither the register nor the set holds the page, the block sends the page number to an external page-table read port. It then waits for the reply, which carries the frame and a present flag. If the page is present, the block stores the entry in a slot and completes the translation. If it is not present, the block raises a fault pulse instead. Only one miss is in flight at a time. While it is in flight, the request port holds its ready low.

Software has two controls. It can invalidate every slot whose tag matches a given page, which also empties the last-translation register. It can also clear all referenced flags in one cycle. A combinational status port exposes one slot's contents, so the flags can be observed.

Top module: `tlb_lastreg`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `rsp_fault` are 0, and every slot reads as invalid on the status port.
- R2: On a miss, `pt_req_valid` rises with `pt_req_vpn` equal to the requested page, and both stay steady until `pt_req_ready` is seen. When a reply arrives with `pt_rsp_present`=1, the block answers with `rsp_valid`=1 and `rsp_pfn` equal to the returned frame.
- R3: A request that misses the last-translation register but matches a valid slot gives `rsp_valid` two cycles after the accepting edge, with that slot's frame. It issues no page-table request. At most one slot matches any page.
- R4: A request that matches the last-translation register gives `rsp_valid` one cycle after the accepting edge, with its frame. It issues no page-table request.
- R5: A reply with `pt_rsp_present`=0 produces a one-cycle `rsp_fault` with `rsp_valid` low, and no slot is written.
- R6: Asserting `inv_en` clears the valid flag of the slot whose tag equals `inv_vpn`, and it also empties the last-translation register. The next access to that page misses and refills through the page-table port.
- R7: Every access sets the referenced flag of the slot it uses, whether that access is a fast hit, a set hit or a refill. A `clr_ref` pulse clears the referenced flag of all slots. When an access and `clr_ref` fall in the same cycle, the accessed slot ends with its flag at 1.
- R8: The modified flag is set by a write access (`req_write`=1), including a refill caused by a write. Reads and `clr_ref` leave it unchanged.
- R9: A refill goes into the lowest-numbered invalid slot. If every slot is valid, it goes into the lowest-numbered slot whose referenced flag is 0. If every referenced flag is 1, it goes into slot 0.
- R10: `req_ready` is 0 while a miss or fault is being served, and in any cycle where `inv_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_pfn | output | PFN_W | Physical frame number of the result |
| rsp_fault | output | 1 | Page-fault exception pulse |
| pt_req_valid | output | 1 | Page-table read request |
| pt_req_ready | input | 1 | Page-table port accepts the request |
| pt_req_vpn | output | VPN_W | Page being looked up |
| pt_rsp_valid | input | 1 | Page-table reply pulse |
| pt_rsp_pfn | input | PFN_W | Frame number from the page table |
| pt_rsp_present | input | 1 | Page is resident in memory |
| inv_en | input | 1 | Invalidate the slot holding `inv_vpn` |
| inv_vpn | input | VPN_W | Page to invalidate |
| clr_ref | input | 1 | Clear every referenced flag |
| st_idx | input | IDX_W | Slot shown on the status port |
| st_valid | output | 1 | Valid flag of the selected slot |
| st_ref | output | 1 | Referenced flag of the selected slot |
| st_mod | output | 1 | Modified flag of the selected slot |
| st_vpn | output | VPN_W | Tag of the selected slot |
| st_pfn | output | PFN_W | Frame of the selected slot |

## Verification
Two functions can fall in the same cycle. A fast hit sets a slot's referenced flag, and a bulk clear resets every such flag. The bench drives `clr_ref` high in the very cycle that a fast-hit request is accepted. It then reads the status port: the accessed slot must show its referenced flag at 1, and every other slot must show 0. A second pairing checks that `req_ready` falls during an invalidate pulse. It also checks that a page held in the last-translation register is not answered quickly after that page has been invalidated.

// File: rtl/tlb_lastreg.sv
module tlb_lastreg #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_fault,
  output logic             pt_req_valid,
  input  logic             pt_req_ready,
  output logic [VPN_W-1:0] pt_req_vpn,
  input  logic             pt_rsp_valid,
  input  logic [PFN_W-1:0] pt_rsp_pfn,
  input  logic             pt_rsp_present,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             clr_ref,
  input  logic [IDX_W-1:0] st_idx,
  output logic             st_valid,
  output logic             st_ref,
  output logic             st_mod,
  output logic [VPN_W-1:0] st_vpn,
  output logic [PFN_W-1:0] st_pfn
);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_PTREQ, S_PTWAIT} state_t;
  state_t state;

  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PFN_W-1:0]   e_pfn [ENTRIES];
  logic [ENTRIES-1:0] e_val, e_ref, e_mod;

  logic             lr_valid;
  logic [VPN_W-1:0] lr_vpn;
  logic [PFN_W-1:0] lr_pfn;
  logic [IDX_W-1:0] lr_idx;

  logic [VPN_W-1:0] q_vpn;
  logic             q_wr;

  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   hit_idx, victim;

  wire accept  = req_valid && req_ready;
  wire lr_hit  = lr_valid && (lr_vpn == req_vpn);
  wire fast    = accept && lr_hit;
  wire arr_hit = (state == S_LOOK) && (|hit_vec);
  wire fill    = (state == S_PTWAIT) && pt_rsp_valid && pt_rsp_present;
  wire fault   = (state == S_PTWAIT) && pt_rsp_valid && !pt_rsp_present;
  wire touch_wr = fast ? req_write : q_wr;

  assign req_ready    = (state == S_IDLE) && !inv_en;
  assign pt_req_valid = (state == S_PTREQ);
  assign pt_req_vpn   = q_vpn;

  assign st_valid = e_val[st_idx];
  assign st_ref   = e_ref[st_idx];
  assign st_mod   = e_mod[st_idx];
  assign st_vpn   = e_vpn[st_idx];
  assign st_pfn   = e_pfn[st_idx];

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    logic found;
    victim = '0;
    found  = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !e_val[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !e_ref[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    wire write_g = fill && (victim == IDX_W'(g));
    wire touch_g = (fast && lr_idx == IDX_W'(g)) ||
                   (arr_hit && hit_idx == IDX_W'(g));

    assign hit_vec[g] = e_val[g] && (e_vpn[g] == q_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_val[g] <= 1'b0;
        e_ref[g] <= 1'b0;
        e_mod[g] <= 1'b0;
        e_vpn[g] <= '0;
        e_pfn[g] <= '0;
      end else begin
        if (inv_en && e_val[g] && e_vpn[g] == inv_vpn) e_val[g] <= 1'b0;
        if (clr_ref) e_ref[g] <= 1'b0;
        if (touch_g) begin
          e_ref[g] <= 1'b1;
          if (touch_wr) e_mod[g] <= 1'b1;
        end
        if (write_g) begin
          e_val[g] <= 1'b1;
          e_ref[g] <= 1'b1;
          e_mod[g] <= q_wr;
          e_vpn[g] <= q_vpn;
          e_pfn[g] <= pt_rsp_pfn;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_valid <= 1'b0;
      lr_vpn   <= '0;
      lr_pfn   <= '0;
      lr_idx   <= '0;
    end else if (inv_en) begin
      lr_valid <= 1'b0;
    end else if (arr_hit) begin
      lr_valid <= 1'b1;
      lr_vpn   <= q_vpn;
      lr_pfn   <= e_pfn[hit_idx];
      lr_idx   <= hit_idx;
    end else if (fill) begin
      lr_valid <= 1'b1;
      lr_vpn   <= q_vpn;
      lr_pfn   <= pt_rsp_pfn;
      lr_idx   <= victim;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      q_vpn <= '0;
      q_wr  <= 1'b0;
    end else begin
      case (state)
        S_IDLE:   if (accept && !lr_hit) begin
                    q_vpn <= req_vpn;
                    q_wr  <= req_write;
                    state <= S_LOOK;
                  end
        S_LOOK:   state <= arr_hit ? S_IDLE : S_PTREQ;
        S_PTREQ:  if (pt_req_ready) state <= S_PTWAIT;
        S_PTWAIT: if (pt_rsp_valid) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      rsp_valid <= fast || arr_hit || fill;
      rsp_fault <= fault;
      if (fast)         rsp_pfn <= lr_pfn;
      else if (arr_hit) rsp_pfn <= e_pfn[hit_idx];
      else if (fill)    rsp_pfn <= pt_rsp_pfn;
    end
  end

endmodule

// File: rtl/tlb_lastreg_chk.sv
module tlb_lastreg_chk #(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [VPN_W-1:0]   req_vpn,
  input logic               rsp_valid,
  input logic [PFN_W-1:0]   rsp_pfn,
  input logic               rsp_fault,
  input logic               pt_req_valid,
  input logic               pt_req_ready,
  input logic [VPN_W-1:0]   pt_req_vpn,
  input logic               inv_en,
  input logic               lr_valid,
  input logic [VPN_W-1:0]   lr_vpn,
  input logic [PFN_W-1:0]   lr_pfn,
  input logic [ENTRIES-1:0] hit_vec
);

  a_r4_fast_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lr_valid && lr_vpn == req_vpn)
      |=> (rsp_valid && rsp_pfn == $past(lr_pfn)));

  a_r10_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_valid |-> !req_ready);

  a_r10_inv_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |-> !req_ready);

  a_r2_ptreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid && !pt_req_ready) |=> (pt_req_valid && $stable(pt_req_vpn)));

  a_r5_fault_no_xlate: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_fault));

  a_r6_inv_clears_last: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !lr_valid);

  a_r3_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

bind tlb_lastreg tlb_lastreg_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vpn(req_vpn), .rsp_valid(rsp_valid), .rsp_pfn(rsp_pfn),
  .rsp_fault(rsp_fault), .pt_req_valid(pt_req_valid),
  .pt_req_ready(pt_req_ready), .pt_req_vpn(pt_req_vpn), .inv_en(inv_en),
  .lr_valid(lr_valid), .lr_vpn(lr_vpn), .lr_pfn(lr_pfn), .hit_vec(hit_vec)
);

// File: tb/test_tlb_lastreg.sv
module test_tlb_lastreg;
  localparam int VPN_W = 20, PFN_W = 16, ENTRIES = 8, IDX_W = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, pt_req_ready = 0, pt_rsp_valid = 0;
  logic pt_rsp_present = 0, inv_en = 0, clr_ref = 0;
  logic [VPN_W-1:0] req_vpn = '0, inv_vpn = '0;
  logic [PFN_W-1:0] pt_rsp_pfn = '0;
  logic [IDX_W-1:0] st_idx = '0;
  logic req_ready, rsp_valid, rsp_fault, pt_req_valid, st_valid, st_ref, st_mod;
  logic [PFN_W-1:0] rsp_pfn, st_pfn;
  logic [VPN_W-1:0] pt_req_vpn, st_vpn;

  tlb_lastreg i_tlb_lastreg (.*);

  always #4 clk = ~clk;

  typedef struct { logic [PFN_W-1:0] pfn; bit fault; int lat; int acc; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0, pt_cnt = 0;
  logic [VPN_W-1:0] cur_vpn = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PFN_W-1:0] pfn_of(logic [VPN_W-1:0] v);
    return v[PFN_W-1:0] ^ 16'hA5A5;
  endfunction
  function automatic bit present_of(logic [VPN_W-1:0] v);
    return v[3:0] != 4'hF;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && (rsp_valid || rsp_fault)) begin
      if (q.size() == 0) chk(0, "R2", "unexpected response", rsp_valid, 0);
      else begin
        e = q.pop_front();
        chk(rsp_fault == e.fault && rsp_valid == !e.fault, e.tag, "fault flag", rsp_fault, e.fault);
        if (!e.fault) chk(rsp_pfn == e.pfn, e.tag, "frame", rsp_pfn, e.pfn);
        if (e.lat != 0) chk(cyc - e.acc == e.lat, e.tag, "latency", cyc - e.acc, e.lat);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && pt_req_valid && !pt_req_ready) begin
        logic [VPN_W-1:0] v;
        chk(req_ready == 0, "R10", "ready during miss", req_ready, 0);
        chk(pt_req_vpn == cur_vpn, "R2", "pt request page", pt_req_vpn, cur_vpn);
        pt_cnt++;
        v = pt_req_vpn;
        @(negedge clk);
        chk(pt_req_valid == 1 && pt_req_vpn == v, "R2", "request held while not ready", pt_req_valid, 1);
        pt_req_ready = 1;
        @(negedge clk);
        pt_req_ready = 0;
        repeat (2) @(negedge clk);
        pt_rsp_valid = 1; pt_rsp_pfn = pfn_of(v); pt_rsp_present = present_of(v);
        @(negedge clk);
        pt_rsp_valid = 0;
      end
    end
  end

  // lat: 1 last-register hit, 2 set hit, 0 miss
  task automatic do_req(logic [VPN_W-1:0] v, bit wr, int lat, bit clr, string tag);
    exp_t e;
    int pt0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    pt0 = pt_cnt;
    cur_vpn = v;
    req_valid = 1; req_vpn = v; req_write = wr; clr_ref = clr;
    e.pfn = pfn_of(v); e.fault = !present_of(v); e.lat = lat; e.acc = cyc; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 0; clr_ref = 0;
    while (q.size() != 0) @(negedge clk);
    chk((pt_cnt - pt0) == (lat == 0 ? 1 : 0), tag, "page-table requests", pt_cnt - pt0, lat == 0);
  endtask

  task automatic ent(int idx, bit v, logic [VPN_W-1:0] vpn, bit r, bit m, string tag);
    st_idx = IDX_W'(idx);
    #1;
    chk(st_valid == v, tag, $sformatf("slot %0d valid", idx), st_valid, v);
    if (v) begin
      chk(st_vpn == vpn, tag, $sformatf("slot %0d tag", idx), st_vpn, vpn);
      chk(st_ref == r, tag, $sformatf("slot %0d ref", idx), st_ref, r);
      chk(st_mod == m, tag, $sformatf("slot %0d mod", idx), st_mod, m);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_ref = 1;
    @(negedge clk); clr_ref = 0;
  endtask

  localparam logic [VPN_W-1:0] PA = 20'h00100, PB = 20'h00201, PF = 20'h0030F;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 0 && rsp_fault == 0, "R1", "no response after reset", rsp_valid, 0);
    for (int i = 0; i < ENTRIES; i++) ent(i, 0, 0, 0, 0, "R1");

    do_req(PA, 0, 0, 0, "R2");
    ent(0, 1, PA, 1, 0, "R9");
    do_req(PA, 0, 1, 0, "R4");
    do_req(PB, 1, 0, 0, "R8");
    ent(1, 1, PB, 1, 1, "R8");
    do_req(PA, 0, 2, 0, "R3");
    do_req(PF, 0, 0, 0, "R5");
    @(negedge clk);
    ent(2, 0, 0, 0, 0, "R5");
    pulse_clr();
    ent(0, 1, PA, 0, 0, "R7");
    ent(1, 1, PB, 0, 1, "R8");
    do_req(PA, 0, 1, 1, "R7");
    ent(0, 1, PA, 1, 0, "R7");
    ent(1, 1, PB, 0, 1, "R7");
    do_req(PB, 0, 2, 0, "R8");
    ent(1, 1, PB, 1, 1, "R8");
    ent(0, 1, PA, 1, 0, "R8");

    @(negedge clk);
    inv_en = 1; inv_vpn = PB;
    #1 chk(req_ready == 0, "R10", "ready during invalidate", req_ready, 0);
    @(negedge clk);
    inv_en = 0;
    ent(1, 0, 0, 0, 0, "R6");
    ent(0, 1, PA, 1, 0, "R6");
    do_req(PB, 0, 0, 0, "R6");
    ent(1, 1, PB, 1, 0, "R6");

    for (int k = 0; k < 6; k++) do_req(20'h00400 + k, 0, 0, 0, "R9");
    for (int k = 0; k < 6; k++) ent(2 + k, 1, 20'h00400 + k, 1, 0, "R9");
    pulse_clr();
    do_req(PA, 0, 2, 0, "R3");
    do_req(20'h00500, 0, 0, 0, "R9");
    ent(1, 1, 20'h00500, 1, 0, "R9");
    for (int k = 0; k < 6; k++) do_req(20'h00400 + k, 0, 2, 0, "R3");
    do_req(20'h00600, 1, 0, 0, "R9");
    ent(0, 1, 20'h00600, 1, 1, "R9");
    do_req(20'h00600, 0, 1, 0, "R4");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R10", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end
endmodule